// File: doc/BRIEF.md
# Real-Time Counter and Watchdog with Shared Prescaler

This block pairs an 8-bit free-running event counter with an 8-bit watchdog. The two share one power-of-two prescaler. The counter advances on either the instruction-clock enable or on a chosen edge of an external pin. The pin is first passed through a two-flop synchronizer and an edge detector. When the counter wraps from its all-ones value to zero, it sets a sticky overflow flag. It also raises a one-cycle interrupt pulse, unless the active-low interrupt-enable bit masks it.

The watchdog counts a slow timebase enable at all times, including while the device is powered down. A single routing bit decides which side the prescaler serves. When the prescaler is routed to the counter, every watchdog overflow is a timeout. When it is routed to the watchdog, the prescaler counts watchdog overflows, which extends the timeout by the selected factor. A timeout in active mode pulses a reset request. A timeout during power-down pulses a wake request instead. The timeout and power-down status flags record which of the two occurred.

A clear command zeroes the watchdog and the prescaler and sets both status flags. Configuration arrives through a 7-bit option register written over a one-cycle write strobe. The counter can also be loaded directly.

Top module: `rtwd_timer`

## Requirements
- R1: After reset the counter is 0 and the overflow flag, interrupt, reset request and wake request are all 0. The timeout flag and the power-down flag are both 1. The option register holds 7'h48: interrupt masked, internal source, prescaler routed to the watchdog, divide field 0.
- R2: Option bit layout is [2:0] divide field n, [3] route (1 = watchdog), [4] edge (1 = falling), [5] source (1 = pin), [6] interrupt mask (active low). With the internal source and the prescaler on the watchdog, the counter adds one on every clock where inst_tick is 1.
- R3: With the prescaler routed to the counter, the counter adds one per 2^(n+1) source ticks.
- R4: With the pin source, edge bit 0 counts rising pin edges and edge bit 1 counts falling edges. The counter changes at the third rising clock edge after the pin changes.
- R5: A count step from 8'hFF to 8'h00 sets ovf_flag. flag_clr clears it. A rollover in the same cycle as flag_clr leaves the flag set.
- R6: A rollover pulses ovf_irq for one cycle only when option bit 6 is 0.
- R7: With the prescaler on the counter, the 256th wdt_tick after a clear causes a one-cycle wdt_reset while sleep is 0. It also sets to_flag=0 and pd_flag=1.
- R8: With the prescaler on the watchdog, the timeout comes after 256*2^n wdt_ticks.
- R9: A timeout while sleep is 1 pulses wdt_wake instead of wdt_reset and sets both status flags to 0.
- R10: wdt_clear zeroes the watchdog and the prescaler and sets to_flag and pd_flag to 1. The next timeout then needs a full period.
- R11: cnt_we loads cnt_wdata into the counter, taking priority over a count step that cycle. When the prescaler is routed to the counter, the load also restarts the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| inst_tick | input | 1 | Instruction-clock enable, internal count source |
| ext_pin | input | 1 | Asynchronous external count pin |
| wdt_tick | input | 1 | Watchdog timebase enable |
| sleep | input | 1 | Device is in power-down |
| cfg_we | input | 1 | Option register write strobe |
| cfg_wdata | input | 7 | Option register write data |
| cnt_we | input | 1 | Counter load strobe |
| cnt_wdata | input | 8 | Counter load value |
| flag_clr | input | 1 | Clear the overflow flag |
| wdt_clear | input | 1 | Watchdog clear command |
| count_q | output | 8 | Counter value |
| ovf_flag | output | 1 | Sticky rollover flag |
| ovf_irq | output | 1 | One-cycle rollover interrupt |
| wdt_reset | output | 1 | One-cycle reset request on active-mode timeout |
| wdt_wake | output | 1 | One-cycle wake request on power-down timeout |
| to_flag | output | 1 | Timeout status, 0 after a timeout |
| pd_flag | output | 1 | Power-down status |

## Verification
A prescaler phase error shows only indirectly. It appears as a counter step or a timeout that lands one or more source ticks early or late, so the checks count exact tick numbers to each step and each timeout. A wrong synchronizer depth shifts every pin-driven step by a clock, which the three-edge latency check exposes at once. The watchdog's internal count is hidden until its timeout, which can lie hundreds of cycles away. For that reason the bench compares every output against a cycle-accurate model on every clock, through long runs and random traffic.

// File: rtl/rtwd_pkg.sv
package rtwd_pkg;
  localparam int OPT_W    = 7;
  localparam int DIV_W    = 3;
  localparam int SHIFT_W  = DIV_W + 1;

  typedef struct packed {
    logic             irq_off;   // bit 6, active-low interrupt enable
    logic             src_pin;   // bit 5
    logic             edge_fall; // bit 4
    logic             ps_wdt;    // bit 3
    logic [DIV_W-1:0] div;       // bits 2:0
  } opt_t;

  localparam opt_t OPT_RST = opt_t'(7'h48);
endpackage

// File: rtl/rtwd_edge_sync.sv
module rtwd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/rtwd_prescaler.sv
module rtwd_prescaler #(
  parameter int PS_W    = 8,
  parameter int SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               tick_in,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick_out
);
  logic [PS_W-1:0] pre_q, pre_d, mask;

  always_comb begin
    mask     = ~({PS_W{1'b1}} << shift);
    tick_out = tick_in & ~clr & ((pre_q & mask) == mask);
    pre_d    = pre_q;
    if (clr)          pre_d = '0;
    else if (tick_in) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/rtwd_count.sv
module rtwd_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         flag_clr,
  input  logic         irq_off,
  output logic [W-1:0] count,
  output logic         ovf_flag,
  output logic         ovf_irq
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         flag_q, flag_d, irq_q, irq_d, roll;

  always_comb begin
    roll   = tick & ~we & (cnt_q == {W{1'b1}});
    cnt_d  = cnt_q;
    if (we)        cnt_d = wdata;
    else if (tick) cnt_d = cnt_q + 1'b1;
    flag_d = flag_q;
    if (roll)          flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    irq_d  = roll & ~irq_off;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign count    = cnt_q;
  assign ovf_flag = flag_q;
  assign ovf_irq  = irq_q;
endmodule

// File: rtl/rtwd_watchdog.sv
module rtwd_watchdog #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clear,
  input  logic sleep,
  input  logic timeout,
  output logic ovf,
  output logic to_flag,
  output logic pd_flag,
  output logic wdt_reset,
  output logic wdt_wake
);
  logic [W-1:0] wc_q, wc_d;
  logic to_q, to_d, pd_q, pd_d, rst_q, rst_d, wake_q, wake_d, fire;

  always_comb begin
    ovf  = tick & ~clear & (wc_q == {W{1'b1}});
    fire = timeout & ~clear;
    wc_d = wc_q;
    if (clear)     wc_d = '0;
    else if (tick) wc_d = wc_q + 1'b1;
    to_d = to_q;
    pd_d = pd_q;
    if (clear) begin
      to_d = 1'b1;
      pd_d = 1'b1;
    end else if (fire) begin
      to_d = 1'b0;
      pd_d = ~sleep;
    end
    rst_d  = fire & ~sleep;
    wake_d = fire & sleep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wc_q   <= '0;
      to_q   <= 1'b1;
      pd_q   <= 1'b1;
      rst_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      wc_q   <= wc_d;
      to_q   <= to_d;
      pd_q   <= pd_d;
      rst_q  <= rst_d;
      wake_q <= wake_d;
    end
  end

  assign to_flag   = to_q;
  assign pd_flag   = pd_q;
  assign wdt_reset = rst_q;
  assign wdt_wake  = wake_q;
endmodule

// File: rtl/rtwd_timer.sv
module rtwd_timer
  import rtwd_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int WDT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inst_tick,
  input  logic             ext_pin,
  input  logic             wdt_tick,
  input  logic             sleep,
  input  logic             cfg_we,
  input  logic [OPT_W-1:0] cfg_wdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             flag_clr,
  input  logic             wdt_clear,
  output logic [CNT_W-1:0] count_q,
  output logic             ovf_flag,
  output logic             ovf_irq,
  output logic             wdt_reset,
  output logic             wdt_wake,
  output logic             to_flag,
  output logic             pd_flag
);
  localparam int PS_W = 1 << DIV_W;

  opt_t opt_q, opt_d;
  logic pin_rise, pin_fall, src_tick, wdt_ovf;
  logic ps_in, ps_out, ps_clr, cnt_tick, timeout;
  logic [SHIFT_W-1:0] ps_shift;
  logic irq_off_w;

  always_comb begin
    opt_d = opt_q;
    if (cfg_we) opt_d = opt_t'(cfg_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) opt_q <= OPT_RST;
    else        opt_q <= opt_d;
  end

  rtwd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise(pin_rise), .fall(pin_fall)
  );

  always_comb begin
    src_tick = opt_q.src_pin ? (opt_q.edge_fall ? pin_fall : pin_rise) : inst_tick;
    ps_in    = opt_q.ps_wdt ? wdt_ovf : src_tick;
    ps_shift = opt_q.ps_wdt ? {1'b0, opt_q.div} : ({1'b0, opt_q.div} + 1'b1);
    ps_clr   = wdt_clear | (cnt_we & ~opt_q.ps_wdt);
    cnt_tick = opt_q.ps_wdt ? src_tick : ps_out;
    timeout  = opt_q.ps_wdt ? ps_out : wdt_ovf;
  end

  rtwd_prescaler #(.PS_W(PS_W), .SHIFT_W(SHIFT_W)) u_ps (
    .clk(clk), .rst_n(rst_n), .clr(ps_clr), .tick_in(ps_in),
    .shift(ps_shift), .tick_out(ps_out)
  );

  rtwd_count #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .we(cnt_we), .wdata(cnt_wdata),
    .flag_clr(flag_clr), .irq_off(opt_q.irq_off), .count(count_q),
    .ovf_flag(ovf_flag), .ovf_irq(ovf_irq)
  );

  rtwd_watchdog #(.W(WDT_W)) u_wdt (
    .clk(clk), .rst_n(rst_n), .tick(wdt_tick), .clear(wdt_clear), .sleep(sleep),
    .timeout(timeout), .ovf(wdt_ovf), .to_flag(to_flag), .pd_flag(pd_flag),
    .wdt_reset(wdt_reset), .wdt_wake(wdt_wake)
  );

  assign irq_off_w = opt_q.irq_off;
endmodule

// File: rtl/rtwd_timer_chk.sv
module rtwd_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wdt_clear,
  input logic             cnt_we,
  input logic [CNT_W-1:0] count_q,
  input logic             ovf_flag,
  input logic             ovf_irq,
  input logic             wdt_reset,
  input logic             wdt_wake,
  input logic             to_flag,
  input logic             pd_flag,
  input logic             irq_off
);
  a_r7_reset_flags: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |-> (!to_flag && pd_flag));
  a_r9_wake_flags: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_wake |-> (!to_flag && !pd_flag));
  a_r9_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    !(wdt_reset && wdt_wake));
  a_r10_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clear |=> (to_flag && pd_flag && !wdt_reset && !wdt_wake));
  a_r6_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> (!$past(irq_off) && ovf_flag));
  a_r5_rollover: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> (count_q == '0));
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we |=> (count_q == $past(count_q) || count_q == $past(count_q) + 1'b1));
endmodule

bind rtwd_timer rtwd_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wdt_clear(wdt_clear), .cnt_we(cnt_we),
  .count_q(count_q), .ovf_flag(ovf_flag), .ovf_irq(ovf_irq),
  .wdt_reset(wdt_reset), .wdt_wake(wdt_wake), .to_flag(to_flag),
  .pd_flag(pd_flag), .irq_off(irq_off_w)
);

// File: tb/rtwd_timer_tb.sv
`timescale 1ns/1ps
module rtwd_timer_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic inst_tick = 0, ext_pin = 0, wdt_tick = 0, sleep = 0, cfg_we = 0;
  logic [6:0] cfg_wdata = '0;
  logic cnt_we = 0, flag_clr = 0, wdt_clear = 0;
  logic [7:0] cnt_wdata = '0;
  logic [7:0] count_q;
  logic ovf_flag, ovf_irq, wdt_reset, wdt_wake, to_flag, pd_flag;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtwd_timer u_dut (.*);

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_cnt, m_flag, m_irq, m_wc, m_pre, m_to, m_pd, m_rst, m_wake, m_opt;
  int pin_hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_flag = 0; m_irq = 0; m_wc = 0; m_pre = 0;
      m_to = 1; m_pd = 1; m_rst = 0; m_wake = 0; m_opt = 'h48;
      pin_hist = '{0, 0, 0};
    end else begin
      int div, psw, src, wov, pin_tick, k, pclr, pout, ctick, tmo, roll;
      div = m_opt & 7; psw = (m_opt >> 3) & 1;
      // pin_hist[1] is the synchronized pin, pin_hist[2] the value a cycle older
      if ((m_opt >> 5) & 1)
        src = ((m_opt >> 4) & 1) ? (!pin_hist[1] && pin_hist[2]) : (pin_hist[1] && !pin_hist[2]);
      else src = inst_tick;
      wov = wdt_tick && !wdt_clear && m_wc == 255;
      pin_tick = psw ? wov : src;
      k = psw ? div : div + 1;
      pclr = wdt_clear || (cnt_we && !psw);
      pout = pin_tick && !pclr && ((m_pre % (1 << k)) == (1 << k) - 1);
      ctick = psw ? src : pout;
      tmo = (psw ? pout : wov) && !wdt_clear;
      if (pclr) m_pre = 0; else if (pin_tick) m_pre = (m_pre + 1) % 256;
      roll = ctick && !cnt_we && m_cnt == 255;
      if (cnt_we) m_cnt = cnt_wdata; else if (ctick) m_cnt = (m_cnt + 1) % 256;
      if (roll) m_flag = 1; else if (flag_clr) m_flag = 0;
      m_irq = roll && !((m_opt >> 6) & 1);
      if (wdt_clear) m_wc = 0; else if (wdt_tick) m_wc = (m_wc + 1) % 256;
      if (wdt_clear) begin m_to = 1; m_pd = 1; end
      else if (tmo) begin m_to = 0; m_pd = !sleep; end
      m_rst = tmo && !sleep; m_wake = tmo && sleep;
      if (cfg_we) m_opt = cfg_wdata;
      pin_hist.push_front(ext_pin); void'(pin_hist.pop_back());
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      check("R2 model count", count_q, m_cnt);
      check("R5 model flag", ovf_flag, m_flag);
      check("R6 model irq", ovf_irq, m_irq);
      check("R7 model reset", wdt_reset, m_rst);
      check("R9 model wake", wdt_wake, m_wake);
      check("R10 model to", to_flag, m_to);
      check("R10 model pd", pd_flag, m_pd);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [6:0] v);
    cfg_we = 1; cfg_wdata = v; cyc(1); cfg_we = 0;
  endtask

  task automatic load(input logic [7:0] v);
    cnt_we = 1; cnt_wdata = v; cyc(1); cnt_we = 0;
  endtask

  task automatic wclr();
    wdt_clear = 1; cyc(1); wdt_clear = 0;
  endtask

  initial begin
    cyc(3); rst_n = 1;
    // R1 reset state
    check("R1 count", count_q, 0); check("R1 flag", ovf_flag, 0);
    check("R1 to", to_flag, 1); check("R1 pd", pd_flag, 1);
    check("R1 reset", wdt_reset, 0);
    // R1/R2: default option, internal source, 5 ticks
    inst_tick = 1; cyc(5); inst_tick = 0;
    check("R2 internal count", count_q, 5);
    // R3: prescaler on counter, divide field 2 -> /8
    cfg(7'h42); load(8'd0);
    inst_tick = 1; cyc(23);
    check("R3 before 24th", count_q, 2);
    cyc(1); inst_tick = 0;
    check("R3 after 24", count_q, 3);
    // R11: load mid-phase restarts prescaler
    inst_tick = 1; cyc(5); inst_tick = 0; load(8'd10);
    inst_tick = 1; cyc(7);
    check("R11 restart", count_q, 10);
    cyc(1); inst_tick = 0;
    check("R11 first step", count_q, 11);
    // R4: pin rising edges, prescaler on watchdog
    cfg(7'h68); load(8'd0);
    ext_pin = 1; cyc(2);
    check("R4 rise latency2", count_q, 0);
    cyc(1);
    check("R4 rise latency3", count_q, 1);
    ext_pin = 0; cyc(4);
    check("R4 fall ignored", count_q, 1);
    cfg(7'h78);
    ext_pin = 1; cyc(4);
    check("R4 rise ignored", count_q, 1);
    ext_pin = 0; cyc(3);
    check("R4 falling", count_q, 2);
    // R5/R6: rollover with interrupt enabled
    cfg(7'h08); load(8'hFF);
    inst_tick = 1; cyc(1); inst_tick = 0;
    check("R5 wrap", count_q, 0); check("R5 flag set", ovf_flag, 1);
    check("R6 irq enabled", ovf_irq, 1);
    cyc(1); check("R6 irq one cycle", ovf_irq, 0);
    flag_clr = 1; cyc(1); flag_clr = 0;
    check("R5 cleared", ovf_flag, 0);
    cfg(7'h48); load(8'hFF);
    inst_tick = 1; flag_clr = 1; cyc(1); inst_tick = 0; flag_clr = 0;
    check("R5 set wins", ovf_flag, 1); check("R6 irq masked", ovf_irq, 0);
    // R7: active timeout, prescaler on counter
    cfg(7'h00); wclr();
    wdt_tick = 1; cyc(255);
    check("R7 not yet", wdt_reset, 0);
    cyc(1); wdt_tick = 0;
    check("R7 reset", wdt_reset, 1); check("R7 to", to_flag, 0); check("R7 pd", pd_flag, 1);
    cyc(1); check("R7 pulse ends", wdt_reset, 0);
    // R10: clear restores flags, full period follows
    wclr(); check("R10 to", to_flag, 1); check("R10 pd", pd_flag, 1);
    wdt_tick = 1; cyc(255); check("R10 full period", wdt_reset, 0);
    cyc(1); wdt_tick = 0; check("R10 timeout", wdt_reset, 1);
    // R8: prescaler on watchdog, divide 2
    cfg(7'h09); wclr();
    wdt_tick = 1; cyc(511);
    check("R8 not at 511", wdt_reset, 0);
    cyc(1); wdt_tick = 0;
    check("R8 at 512", wdt_reset, 1);
    // R9: sleeping timeout
    cfg(7'h00); wclr(); sleep = 1;
    wdt_tick = 1; cyc(256); wdt_tick = 0;
    check("R9 wake", wdt_wake, 1); check("R9 no reset", wdt_reset, 0);
    check("R9 to", to_flag, 0); check("R9 pd", pd_flag, 0);
    sleep = 0;
    // random traffic against the model
    for (int i = 0; i < 6000; i++) begin
      inst_tick = $urandom_range(0, 1); ext_pin = $urandom_range(0, 1);
      wdt_tick = $urandom_range(0, 1); sleep = ($urandom_range(0, 7) == 0);
      cfg_we = ($urandom_range(0, 63) == 0); cfg_wdata = 7'($urandom);
      cnt_we = ($urandom_range(0, 31) == 0); cnt_wdata = 8'($urandom);
      flag_clr = ($urandom_range(0, 15) == 0);
      wdt_clear = ($urandom_range(0, 255) == 0);
      cyc(1);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule